// File: doc/BRIEF.md
# Infrared Remote Transmit Modulator

This block produces the drive signal for an infrared emitter. A transmission is a chain of segments. Each segment is one data bit and a length value. While a segment with a one bit is active, the carrier input passes to the output pin. During a zero bit the pin is held low. The length of each segment is timed by an 8-bit down counter. That counter advances on ticks from a prescaler, which divides the block clock by a power of two picked by a 4-bit select field.

Software writes the next bit and length into a staging register at any time. When the running counter passes zero, the staged segment becomes current and counting restarts. If software has not written anything new, the previous segment repeats. The same event sets an interrupt flag when interrupts are enabled, so software knows when to stage the following segment. The mode, clock select and interrupt enable are frozen while the block is enabled. The enable bit itself stays writable.

Top module: `ir_tx_modulator`

## Requirements
- R1: After reset, `ir_out` and `irq` are 0, staged bit and length are 0, mode is transmit and the clock select is 0, so the first run without a configuration write counts on every clock.
- R2: While enabled in transmit mode, `ir_out` equals `carrier_in` when the current bit is 1. It is 0 when the current bit is 0, when the block is disabled, or when it is in receive mode.
- R3: With a length L (0..255) and select code N, the counter underflows (L+1)*2^N clocks after the edge that enables the block. Length 255 gives 256 counts.
- R4: Select codes 0 to 14 divide the clock by 2^N. Code 14 gives one count per 16384 clocks.
- R5: Select code 15 is reserved and gives no counts. The current segment never ends, and its bit keeps driving the output.
- R6: On enable and on every underflow, the staged bit and length become current. Without a new `seg_we` write, the same segment repeats.
- R7: When `cfg_irq_en` is set, each underflow sets `irq`. The flag stays set until `irq_clr` is pulsed. With the enable at 0, an underflow leaves `irq` at 0.
- R8: While the block is enabled, `cfg_we` writes have no effect. `en_we` can still turn the block off.
- R9: Mode value 1 (receive) keeps `ir_out` low and the counter idle, so no interrupt occurs.
- R10: With the staged bit at 0 and the length at 0 at enable time, nothing is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the prescaler source |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_we | input | 1 | Write strobe for the enable bit |
| en_val | input | 1 | New enable value |
| cfg_we | input | 1 | Write strobe for mode, select and interrupt enable (ignored while enabled) |
| cfg_mode | input | 1 | 0 = transmit, 1 = receive |
| cfg_div | input | 4 | Prescaler select code N (15 reserved) |
| cfg_irq_en | input | 1 | Interrupt enable |
| seg_we | input | 1 | Write strobe for the staged segment |
| seg_bit | input | 1 | Staged data bit |
| seg_len | input | 8 | Staged length value |
| irq_clr | input | 1 | Write-one-to-clear pulse for the interrupt flag |
| carrier_in | input | 1 | Carrier waveform to be gated |
| ir_out | output | 1 | Modulated output pin |
| irq | output | 1 | Underflow interrupt flag |

## Verification
The enabling edge is taken as cycle E. The interrupt flag rises exactly at cycle E+(L+1)*2^N, one register after the counter's final tick. A scoreboard queue holds that exact cycle number, and a monitor compares each rising edge of the flag against it. The output pin is a combinational gate of registered state and the carrier, so it is sampled at mid-cycle right after the stimulus. A new segment shows on the pin from the cycle after the underflow edge. Each boundary case (length 255, select code 14, the reserved code) also gets a check one cycle before the due cycle.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;
    localparam int LEN_BITS = 8;
    localparam int SEL_BITS = 4;

    typedef enum logic {
        MODE_TX = 1'b0,
        MODE_RX = 1'b1
    } ir_mode_e;
endpackage

// File: rtl/ir_tx_prescaler.sv
module ir_tx_prescaler
    import ir_tx_pkg::*;
#(
    parameter int SEL_W = SEL_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    // Largest usable shift: all codes except the all-ones code.
    localparam int CNT_W = (1 << SEL_W) - 2;
    localparam logic [SEL_W-1:0] SEL_RSVD = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_s;

    pre_s             pre_d, pre_q;
    logic [CNT_W-1:0] mask;

    always_comb begin
        mask      = ~({CNT_W{1'b1}} << sel);
        tick      = run && (sel != SEL_RSVD) && ((pre_q.cnt & mask) == mask);
        pre_d.cnt = run ? pre_q.cnt + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/ir_tx_seg_timer.sv
module ir_tx_seg_timer
    import ir_tx_pkg::*;
#(
    parameter int LEN_W = LEN_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tick,
    input  logic             nxt_bit,
    input  logic [LEN_W-1:0] nxt_len,
    output logic             cur_bit,
    output logic             underflow
);
    typedef struct packed {
        logic             bit_v;
        logic [LEN_W-1:0] cnt;
    } seg_s;

    seg_s seg_d, seg_q;

    always_comb begin
        seg_d     = seg_q;
        underflow = tick && (seg_q.cnt == '0);
        if (start || underflow) begin
            seg_d.bit_v = nxt_bit;
            seg_d.cnt   = nxt_len;
        end else if (tick) begin
            seg_d.cnt = seg_q.cnt - 1'b1;
        end
        cur_bit = seg_q.bit_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seg_q <= '0;
        else        seg_q <= seg_d;
    end
endmodule

// File: rtl/ir_tx_modulator.sv
module ir_tx_modulator
    import ir_tx_pkg::*;
#(
    parameter int LEN_W = LEN_BITS,
    parameter int SEL_W = SEL_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_we,
    input  logic             en_val,
    input  logic             cfg_we,
    input  logic             cfg_mode,
    input  logic [SEL_W-1:0] cfg_div,
    input  logic             cfg_irq_en,
    input  logic             seg_we,
    input  logic             seg_bit,
    input  logic [LEN_W-1:0] seg_len,
    input  logic             irq_clr,
    input  logic             carrier_in,
    output logic             ir_out,
    output logic             irq
);
    typedef struct packed {
        logic             en;
        ir_mode_e         mode;
        logic [SEL_W-1:0] div_sel;
        logic             irq_en;
        logic             nxt_bit;
        logic [LEN_W-1:0] nxt_len;
        logic             irq;
    } top_s;

    top_s             st_d, st_q;
    logic             en_q, rx_q, irq_en_q, tx_on, start;
    logic [SEL_W-1:0] div_q;
    logic             tick, cur_bit, underflow;

    assign en_q     = st_q.en;
    assign rx_q     = (st_q.mode == MODE_RX);
    assign div_q    = st_q.div_sel;
    assign irq_en_q = st_q.irq_en;
    assign tx_on    = en_q && !rx_q;

    always_comb begin
        st_d  = st_q;
        start = en_we && en_val && !en_q;
        if (en_we) st_d.en = en_val;
        if (cfg_we && !en_q) begin
            st_d.mode    = ir_mode_e'(cfg_mode);
            st_d.div_sel = cfg_div;
            st_d.irq_en  = cfg_irq_en;
        end
        if (seg_we) begin
            st_d.nxt_bit = seg_bit;
            st_d.nxt_len = seg_len;
        end
        if (irq_clr) st_d.irq = 1'b0;
        if (underflow && irq_en_q) st_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    ir_tx_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (tx_on),
        .sel  (div_q),
        .tick (tick)
    );

    ir_tx_seg_timer #(.LEN_W(LEN_W)) u_seg (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tick     (tick),
        .nxt_bit  (st_q.nxt_bit),
        .nxt_len  (st_q.nxt_len),
        .cur_bit  (cur_bit),
        .underflow(underflow)
    );

    assign ir_out = tx_on && cur_bit && carrier_in;
    assign irq    = st_q.irq;
endmodule

// File: rtl/ir_tx_checker.sv
module ir_tx_checker #(
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_q,
    input logic             rx_q,
    input logic [SEL_W-1:0] div_q,
    input logic             irq_en_q,
    input logic             irq,
    input logic             irq_clr,
    input logic             ir_out,
    input logic             cur_bit,
    input logic             tick,
    input logic             underflow
);
    p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q || rx_q) |-> !ir_out);

    p_zero_bit_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !cur_bit) |-> !ir_out);

    p_reserved_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == '1) |-> !tick);

    p_underflow_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> tick);

    p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(irq_en_q) && $past(underflow)));

    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_q) |-> ($stable(div_q) && $stable(rx_q) && $stable(irq_en_q)));

    p_rx_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q |-> (!tick && !ir_out));
endmodule

bind ir_tx_modulator ir_tx_checker #(.SEL_W(SEL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_q     (en_q),
    .rx_q     (rx_q),
    .div_q    (div_q),
    .irq_en_q (irq_en_q),
    .irq      (irq),
    .irq_clr  (irq_clr),
    .ir_out   (ir_out),
    .cur_bit  (cur_bit),
    .tick     (tick),
    .underflow(underflow)
);

// File: tb/tb_ir_tx_modulator.sv
`timescale 1ns/1ps
module tb_ir_tx_modulator;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_we = 0, en_val = 0, cfg_we = 0, cfg_mode = 0, cfg_irq_en = 0;
    logic [3:0] cfg_div = '0;
    logic       seg_we = 0, seg_bit = 0, irq_clr = 0, carrier_in = 0;
    logic [7:0] seg_len = '0;
    logic       ir_out, irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;
    int exp_q[$];
    logic irq_prev = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ir_tx_modulator dut (
        .clk(clk), .rst_n(rst_n),
        .en_we(en_we), .en_val(en_val),
        .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_div(cfg_div), .cfg_irq_en(cfg_irq_en),
        .seg_we(seg_we), .seg_bit(seg_bit), .seg_len(seg_len),
        .irq_clr(irq_clr), .carrier_in(carrier_in),
        .ir_out(ir_out), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic write_en(input logic v, output int e);
        @(negedge clk); en_we = 1; en_val = v;
        @(negedge clk); en_we = 0;
        e = cyc;
    endtask

    task automatic write_cfg(input logic m, input logic [3:0] d, input logic ie);
        @(negedge clk); cfg_we = 1; cfg_mode = m; cfg_div = d; cfg_irq_en = ie;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic write_seg(input logic b, input logic [7:0] l);
        @(negedge clk); seg_we = 1; seg_bit = b; seg_len = l;
        @(negedge clk); seg_we = 0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); irq_clr = 1;
        @(negedge clk); irq_clr = 0;
    endtask

    // Monitor: every rising edge of irq must match the next expected cycle.
    always @(negedge clk) begin
        if (rst_n && irq && !irq_prev) begin
            if (exp_q.size() == 0) check("R7 unexpected irq", 1, 0);
            else check("R3 irq timing", cyc, exp_q.pop_front());
        end
        irq_prev = irq;
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        int e;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 ir_out reset", ir_out, 0);
        check("R1 irq reset", irq, 0);

        // R10: staged bit 0, length 0 from reset -> nothing emitted
        carrier_in = 1;
        write_en(1, e);
        check("R10 no emission", ir_out, 0);
        wait_to(e + 3);
        check("R10 no emission later", ir_out, 0);
        check("R7 irq gated by enable", irq, 0);
        write_en(0, e);

        // R1/R2/R6: default divide-by-1, bit 1 length 3, then staged bit 0
        write_seg(1, 8'd3);
        write_en(1, e);
        check("R2 carrier passes", ir_out, 1);
        write_seg(0, 8'd5);
        wait_to(e + 3);
        check("R1 default select still bit 1", ir_out, 1);
        wait_to(e + 4);
        check("R6 staged bit 0 loaded", ir_out, 0);
        write_en(0, e);
        check("R2 disabled low", ir_out, 0);

        // R3/R7/R8/R6: select 2, length 2, irq enabled
        write_cfg(0, 4'd2, 1);
        write_seg(1, 8'd2);
        write_en(1, e);
        exp_q.push_back(e + 12);
        exp_q.push_back(e + 24);
        exp_q.push_back(e + 36);
        wait_to(e + 1);
        carrier_in = 0; #1;
        check("R2 carrier low gated", ir_out, 0);
        carrier_in = 1; #1;
        check("R2 carrier high gated", ir_out, 1);
        wait_to(e + 11);
        check("R3 no early underflow", irq, 0);
        wait_to(e + 12);
        check("R3 underflow due", irq, 1);
        write_cfg(0, 4'd0, 0);  // R8: must be ignored
        wait_to(e + 20);
        check("R7 flag held", irq, 1);
        pulse_clr();
        check("R7 flag cleared", irq, 0);
        wait_to(e + 25);
        pulse_clr();
        wait_to(e + 35);
        check("R8 select unchanged", irq, 0);
        wait_to(e + 36);
        check("R8 irq enable unchanged", irq, 1);
        check("R6 repeated segment bit", ir_out, 1);
        write_en(0, e);
        pulse_clr();

        // R5: reserved code never ends a segment
        write_cfg(0, 4'hF, 1);
        write_seg(1, 8'd0);
        write_en(1, e);
        wait_to(e + 300);
        check("R5 no underflow", irq, 0);
        check("R5 bit keeps driving", ir_out, 1);
        write_en(0, e);

        // R4: select 6, length 1 -> 128 clocks
        write_cfg(0, 4'd6, 1);
        write_seg(1, 8'd1);
        write_en(1, e);
        exp_q.push_back(e + 128);
        wait_to(e + 127);
        check("R4 div64 not early", irq, 0);
        wait_to(e + 128);
        check("R4 div64 due", irq, 1);
        write_en(0, e);
        pulse_clr();

        // R4: select 14, length 0 -> 16384 clocks
        write_cfg(0, 4'd14, 1);
        write_seg(0, 8'd0);
        write_en(1, e);
        exp_q.push_back(e + 16384);
        wait_to(e + 16383);
        check("R4 div16384 not early", irq, 0);
        wait_to(e + 16384);
        check("R4 div16384 due", irq, 1);
        write_en(0, e);
        pulse_clr();

        // R3: length 255 -> 256 counts
        write_cfg(0, 4'd0, 1);
        write_seg(1, 8'd255);
        write_en(1, e);
        exp_q.push_back(e + 256);
        wait_to(e + 255);
        check("R3 len255 not early", irq, 0);
        wait_to(e + 256);
        check("R3 len255 due", irq, 1);
        write_en(0, e);
        pulse_clr();

        // R9: receive mode is silent
        write_cfg(1, 4'd0, 1);
        write_seg(1, 8'd0);
        write_en(1, e);
        wait_to(e + 20);
        check("R9 output low", ir_out, 0);
        check("R9 no irq", irq, 0);
        write_en(0, e);

        check("R3 all expected irqs seen", exp_q.size(), 0);
        finish_run();
    end
endmodule